// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

This block collects level-sensitive interrupt requests from 40 primary sources and 32 secondary sources and drives a single interrupt line to a CPU. All secondary sources feed primary source 0. Software reaches the block through a simple 32-bit register port. A write to the port takes effect at the clock edge where the request is seen. Read data appears on the cycle after the read request.

Each bank has its own registers. Enable bits are set through one register and cleared through another, and writing a one is what acts in both. Pending bits are acknowledged by writing ones. The index register gives the remapped number of the lowest-numbered active primary channel. When it reads 0, the only active primary source is the cascade, and software turns to the secondary status register. A remap table holds one entry per channel and sets the number that the index register reports for that channel.

Top module: `cvic_top`

## Requirements
- R1: After reset, all enable and pending bits are 0, `irq_o` is 0, the index register reads 0, and map entry c reads c.
- R2: Primary source n lives in word n/32 and bit n%32 of each primary register. Words sit 4 bytes apart from the base of the register. The primary register bases are: pending (read) and pending-clear (write) at 0x10, enable-set at 0x20, enable-clear at 0x30.
- R3: Writing a 1 to an enable-set bit sets that enable. Writing a 1 to an enable-clear bit clears it. Zero bits leave the enable unchanged. Reads of either the set or the clear register return the current enable mask.
- R4: The index register at 0x40 returns, in bits 5:0, the map entry of the lowest-numbered primary channel c in 1..39 that is both pending and enabled. It returns 0 when there is no such channel. Bits 31:6 always read 0.
- R5: A pending bit becomes 1 on the clock edge after its input is seen high. A pending-clear write clears the bit only if the input is low on that edge. Otherwise the bit stays set.
- R6: `irq_o` is 1 exactly when some primary source is both pending and enabled. A pending source that is disabled does not raise it.
- R7: Map entry c is at 0x200 + 4*c. Only bits 5:0 are stored. A read returns the stored bits with bits 31:6 zero.
- R8: The secondary registers are: status (read) at 0x80, pending-clear at 0x88 (reads return status), enable-set at 0x90, enable-clear at 0x98 (both read back the secondary enable mask). Bit k belongs to secondary source k. Primary source 0 has an effective input equal to its own input OR'd with any secondary source that is both pending and enabled.
- R9: Read data appears on `rdata_o` in the cycle after the read request and holds until the next read. A read of an address with no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after request |
| prim_src_i | input | 40 | Primary level-sensitive sources |
| sec_src_i | input | 32 | Secondary level-sensitive sources |
| irq_o | output | 1 | Interrupt to CPU |

## Verification
The assertions check the following on every cycle:
- A high input always leaves its pending bit set on the next edge.
- No pending bit rises without its input.
- Set and clear writes reach the enable mask.
- An enabled pending secondary source always makes primary 0 pending.
- The index is zero whenever the interrupt line is low.

The following can only be shown by the bench's scenarios:
- The word and bit placement of each source.
- Lowest-channel priority.
- Remapping, including the 6-bit truncation of map entries.
- The rule that a clear write does not take effect while the input is still high.
- The sequence software uses to walk the secondary bank through primary 0.

// File: rtl/cvic_pkg.sv
package cvic_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS_PCLR  = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ESET  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_ECLR  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_INDEX = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_SSTAT = 12'h080;
  localparam logic [ADDR_W-1:0] OFS_SCLR  = 12'h088;
  localparam logic [ADDR_W-1:0] OFS_SSET  = 12'h090;
  localparam logic [ADDR_W-1:0] OFS_SECLR = 12'h098;
  localparam logic [ADDR_W-1:0] OFS_MAP   = 12'h200;
endpackage

// File: rtl/cvic_bank.sv
module cvic_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] pclr_i,
  input  logic [N-1:0] eset_i,
  input  logic [N-1:0] eclr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);
  logic [N-1:0] pend_q, en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      // level: a live input overrides a clear
      pend_q <= src_i | (pend_q & ~pclr_i);
      en_q   <= (en_q | eset_i) & ~eclr_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

  p_level_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(src_i)) == $past(src_i)));
  p_no_spont_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(src_i)) == '0));
  p_en_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eset_i && !(|(eset_i & eclr_i))) |=> ((en_q & $past(eset_i)) == $past(eset_i)));
  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eclr_i) |=> ((en_q & $past(eclr_i)) == '0));
endmodule

// File: rtl/cvic_map.sv
module cvic_map #(
  parameter int unsigned NCH   = 40,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CH_W-1:0]  sel_i,
  input  logic [IDX_W-1:0] wdata_i,
  input  logic [NCH-1:1]   act_i,
  output logic [IDX_W-1:0] entry_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] map_q [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          map_q[c] <= IDX_W'(c);
      else if (we_i && sel_i == CH_W'(c))   map_q[c] <= wdata_i;
    end
  end

  always_comb begin
    entry_o = '0;
    for (int c = 0; c < NCH; c++)
      if (sel_i == CH_W'(c)) entry_o = map_q[c];
  end

  // channel 0 is the cascade: never reported, 0 means "go to secondary"
  always_comb begin
    idx_o = '0;
    for (int c = NCH - 1; c >= 1; c--)
      if (act_i[c]) idx_o = map_q[c];
  end
endmodule

// File: rtl/cvic_top.sv
module cvic_top
  import cvic_pkg::*;
#(
  parameter int unsigned NPRIM = 40,
  parameter int unsigned NSEC  = 32,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned CH_W = $clog2(NPRIM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPRIM-1:0]  prim_src_i,
  input  logic [NSEC-1:0]   sec_src_i,
  output logic              irq_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  function automatic logic [NPRIM-1:0] pick_p(input logic [ADDR_W-1:0] a,
                                              input logic [ADDR_W-1:0] base,
                                              input logic [31:0] d);
    pick_p = '0;
    for (int b = 0; b < NPRIM; b++)
      if (a == base + ADDR_W'(4 * (b / 32))) pick_p[b] = d[b % 32];
  endfunction

  function automatic logic [NSEC-1:0] pick_s(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] base,
                                             input logic [31:0] d);
    pick_s = '0;
    if (a == base)
      for (int b = 0; b < NSEC; b++) pick_s[b] = d[b];
  endfunction

  logic [NPRIM-1:0] p_pclr, p_eset, p_eclr, p_pend, p_en, p_src;
  logic [NSEC-1:0]  s_pclr, s_eset, s_eclr, s_pend, s_en;
  logic             casc;

  assign p_pclr = wr ? pick_p(addr_i, OFS_PCLR, wdata_i)  : '0;
  assign p_eset = wr ? pick_p(addr_i, OFS_ESET, wdata_i)  : '0;
  assign p_eclr = wr ? pick_p(addr_i, OFS_ECLR, wdata_i)  : '0;
  assign s_pclr = wr ? pick_s(addr_i, OFS_SCLR, wdata_i)  : '0;
  assign s_eset = wr ? pick_s(addr_i, OFS_SSET, wdata_i)  : '0;
  assign s_eclr = wr ? pick_s(addr_i, OFS_SECLR, wdata_i) : '0;

  cvic_bank #(.N(NSEC)) u_sec (
    .clk_i, .rst_ni, .src_i(sec_src_i), .pclr_i(s_pclr), .eset_i(s_eset),
    .eclr_i(s_eclr), .pend_o(s_pend), .en_o(s_en)
  );

  assign casc  = |(s_pend & s_en);
  assign p_src = prim_src_i | {{(NPRIM-1){1'b0}}, casc};

  cvic_bank #(.N(NPRIM)) u_prim (
    .clk_i, .rst_ni, .src_i(p_src), .pclr_i(p_pclr), .eset_i(p_eset),
    .eclr_i(p_eclr), .pend_o(p_pend), .en_o(p_en)
  );

  logic [NPRIM-1:0] p_act;
  assign p_act = p_pend & p_en;
  assign irq_o = |p_act;

  logic [ADDR_W-1:0] map_off;
  logic              in_map;
  logic [CH_W-1:0]   map_sel;
  logic [IDX_W-1:0]  map_entry, idx;

  assign map_off = addr_i - OFS_MAP;
  assign in_map  = (map_off < ADDR_W'(4 * NPRIM)) && (map_off[1:0] == 2'b00);
  assign map_sel = map_off[CH_W+1:2];

  cvic_map #(.NCH(NPRIM), .IDX_W(IDX_W)) u_map (
    .clk_i, .rst_ni, .we_i(wr & in_map), .sel_i(map_sel),
    .wdata_i(wdata_i[IDX_W-1:0]), .act_i(p_act[NPRIM-1:1]),
    .entry_o(map_entry), .idx_o(idx)
  );

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NPRIM; b++) begin
      if (addr_i == OFS_PCLR + ADDR_W'(4 * (b / 32))) rd_d[b % 32] = p_pend[b];
      if (addr_i == OFS_ESET + ADDR_W'(4 * (b / 32)) ||
          addr_i == OFS_ECLR + ADDR_W'(4 * (b / 32))) rd_d[b % 32] = p_en[b];
    end
    for (int b = 0; b < NSEC; b++) begin
      if (addr_i == OFS_SSTAT || addr_i == OFS_SCLR)  rd_d[b] = s_pend[b];
      if (addr_i == OFS_SSET  || addr_i == OFS_SECLR) rd_d[b] = s_en[b];
    end
    if (addr_i == OFS_INDEX) rd_d[IDX_W-1:0] = idx;
    if (in_map)              rd_d[IDX_W-1:0] = map_entry;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_d;
  end

  p_idx_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (idx == '0));
  p_cascade_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(s_pend & s_en)) |=> p_pend[0]);
  p_rd_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: tb/tb_cvic_top.sv
module tb_cvic_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [39:0] psrc = '0;
  logic [31:0] ssrc = '0;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cvic_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .prim_src_i(psrc), .sec_src_i(ssrc),
    .irq_o(irq)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  // monitor: a read registered at a posedge is compared at the next negedge
  always @(posedge clk) rd_seen <= req & ~we;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(1);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    tick(1);
    req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq_o=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(12'h010, 32'h0, "R1 pending reset");
    rd(12'h020, 32'h0, "R1 enable reset");
    rd(12'h040, 32'h0, "R1 index reset");
    rd(12'h214, 32'd5, "R1 map identity entry 5");
    rd(12'h080, 32'h0, "R1 secondary status reset");
    // R3 enable set/clear
    wr(12'h020, 32'h28);
    rd(12'h020, 32'h28, "R3 enable set readback");
    wr(12'h020, 32'h0);
    rd(12'h030, 32'h28, "R3 zero write no effect, clear reg reads mask");
    // R6/R2/R4 single source
    psrc[5] = 1'b1;
    tick(1);
    chk_irq(1'b1, "R6 enabled pending raises irq");
    rd(12'h010, 32'h20, "R2 source 5 at word0 bit5");
    rd(12'h040, 32'd5, "R4 index single source");
    psrc[3] = 1'b1;
    tick(1);
    rd(12'h040, 32'd3, "R4 lowest channel wins");
    // R5 level hold
    wr(12'h010, 32'h20);
    rd(12'h010, 32'h28, "R5 clear ignored while input high");
    psrc[5] = 1'b0;
    wr(12'h010, 32'h20);
    rd(12'h010, 32'h08, "R5 clear after input low");
    psrc[3] = 1'b0;
    wr(12'h010, 32'h08);
    tick(1);
    chk_irq(1'b0, "R6 irq drops after ack");
    rd(12'h040, 32'h0, "R4 index zero when idle");
    // R6 disabled source
    psrc[10] = 1'b1;
    tick(1);
    chk_irq(1'b0, "R6 disabled pending no irq");
    rd(12'h010, 32'h400, "R5 disabled source still pending");
    psrc[10] = 1'b0;
    wr(12'h010, 32'h400);
    // R2 word 1
    wr(12'h024, 32'h10);
    psrc[36] = 1'b1;
    tick(1);
    rd(12'h014, 32'h10, "R2 source 36 at word1 bit4");
    rd(12'h040, 32'd36, "R4 index source 36");
    chk_irq(1'b1, "R6 word1 source irq");
    // R7 remap
    wr(12'h290, 32'hFFFF_FFC7);
    rd(12'h290, 32'h07, "R7 map stores 6 bits");
    rd(12'h040, 32'h07, "R4 index after remap");
    wr(12'h290, 32'h3F);
    rd(12'h040, 32'h3F, "R4 index upper bits zero");
    psrc[36] = 1'b0;
    wr(12'h014, 32'h10);
    wr(12'h034, 32'h10);
    rd(12'h024, 32'h0, "R3 enable clear word1");
    // R8 secondary
    wr(12'h020, 32'h01);
    ssrc[9] = 1'b1;
    tick(1);
    rd(12'h080, 32'h200, "R8 secondary status");
    rd(12'h010, 32'h0, "R8 disabled secondary no cascade");
    chk_irq(1'b0, "R8 disabled secondary no irq");
    wr(12'h090, 32'h200);
    tick(1);
    rd(12'h010, 32'h01, "R8 cascade sets primary 0");
    chk_irq(1'b1, "R8 cascade irq");
    rd(12'h040, 32'h0, "R4 index 0 for cascade only");
    rd(12'h098, 32'h200, "R8 secondary enable readback");
    wr(12'h010, 32'h01);
    rd(12'h010, 32'h01, "R8 primary 0 holds while secondary live");
    ssrc[9] = 1'b0;
    wr(12'h088, 32'h200);
    wr(12'h010, 32'h01);
    tick(1);
    rd(12'h088, 32'h0, "R8 secondary cleared");
    rd(12'h010, 32'h0, "R8 primary 0 cleared");
    chk_irq(1'b0, "R8 irq drops");
    // R9 unmapped
    rd(12'h100, 32'h0, "R9 unmapped reads zero");
    tick(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule